// File: doc/BRIEF.md
# Decimal Digit Store and Register Spill/Fill Sequencer

This block runs the multi-byte memory operations of a small interpreter CPU. It sits between a sixteen-entry, 8-bit register file and a byte-addressed memory with 12-bit addresses. Decode issues one command, and the block then carries it out one byte per cycle. A command names an operation, a register number x and a base address I.

There are three operations. The first splits register x into three decimal digits and writes them to I, I+1 and I+2. The split is done by an iterative shift-and-add-3 converter, not a divider. The second spills registers 0 through x into consecutive bytes starting at I. The third fills registers 0 through x from consecutive bytes starting at I. Addresses wrap from 0xFFF back to 0x000. The block only reads the base address and never changes it. Updating the index register is left to the caller.

The register file is read combinationally. Memory reads return their data one cycle after the read strobe. A single-cycle completion pulse marks the end of each operation, and the block then returns to idle.

Top module: `bcd_xfer_seq`

## Requirements
- R1: After reset the block is idle: busy, done, mem_we, mem_re and rf_we are all low.
- R2: A command is taken only when cmd_valid is high while busy is low and cmd_op is nonzero. The encodings are 2'b01 decimal digit store, 2'b10 register spill and 2'b11 register fill. cmd_op 2'b00 and any command presented while busy are ignored: no strobe results and memory stays unchanged.
- R3: The digit store writes the hundreds digit of register x to I, the tens digit to I+1 and the ones digit to I+2. Each digit is one byte with a value from 0 to 9.
- R4: The spill writes register k to address I+k for k = 0..x, in increasing k, one byte per cycle at consecutive addresses.
- R5: The fill reads address I+k into register k for k = 0..x. Each register write follows its memory read by exactly one cycle. Registers above x are left unchanged.
- R6: Every computed address is (I + offset) modulo 4096, so transfers past 0xFFF continue at 0x000.
- R7: done is high for exactly one cycle, one cycle after the last memory or register access of the operation. busy is low in the cycle that follows.
- R8: mem_we and mem_re are never high together. No strobe is raised while idle or in the done cycle. Bytes outside the operation's address range are never written.
- R9: x = 0 moves exactly one byte and x = 15 moves all sixteen registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Operation: 01 digit store, 10 spill, 11 fill, 00 none |
| cmd_reg | input | 4 | Register number x |
| cmd_index | input | 12 | Base address I |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | 12 | Memory write address |
| mem_wdata | output | 8 | Memory write byte |
| mem_re | output | 1 | Memory read strobe |
| mem_raddr | output | 12 | Memory read address |
| mem_rdata | input | 8 | Read byte, valid the cycle after mem_re |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 8 | Register file read data, combinational |
| rf_we | output | 1 | Register file write strobe |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 8 | Register file write data |

## Verification
The assertions assume three things about the environment. The register file returns the addressed byte in the same cycle. Memory answers a read strobe exactly one cycle later. Reset is held low from time zero until the first edges have passed. The bench models both storage arrays with exactly that timing. It drives commands only on the falling edge and holds cmd_valid for a single cycle, except in the scenario that deliberately presses a command against a busy block. Register and memory contents are seeded with distinct patterns, so a wrong index, a wrong address or a stray write shows up in the final comparison.

// File: rtl/bxs_pkg.sv
package bxs_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_BCD   = 2'b01,
        OP_STORE = 2'b10,
        OP_LOAD  = 2'b11
    } bxs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BCD_RD,
        ST_BCD_CONV,
        ST_BCD_WR,
        ST_STORE,
        ST_LOAD,
        ST_LOAD_TAIL,
        ST_FIN
    } bxs_state_e;

endpackage

// File: rtl/bxs_addr_wrap.sv
module bxs_addr_wrap #(
    parameter int AW = 12,
    parameter int OW = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [OW-1:0] off_i,
    output logic [AW-1:0] addr_o
);
    // modulo-2^AW sum; the carry out of the top bit is dropped
    assign addr_o = base_i + AW'(off_i);
endmodule

// File: rtl/bxs_dabble.sv
module bxs_dabble #(
    parameter int DW   = 8,
    parameter int NDIG = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DW-1:0]        value_i,
    output logic                 idle_o,
    output logic [NDIG-1:0][3:0] digits_o
);
    localparam int SW = NDIG * 4 + DW;
    localparam int CW = $clog2(DW + 1);

    typedef struct packed {
        logic [SW-1:0] sh;
        logic [CW-1:0] cnt;
    } dab_t;

    dab_t d_d, d_q;
    logic [SW-1:0] adj;

    // binary bits pass through untouched, each decimal nibble is corrected
    assign adj[DW-1:0] = d_q.sh[DW-1:0];
    for (genvar gi = 0; gi < NDIG; gi++) begin : g_adj
        assign adj[DW+4*gi +: 4] = (d_q.sh[DW+4*gi +: 4] >= 4'd5)
                                   ? d_q.sh[DW+4*gi +: 4] + 4'd3
                                   : d_q.sh[DW+4*gi +: 4];
        assign digits_o[gi] = d_q.sh[DW+4*gi +: 4];
    end

    always_comb begin
        d_d = d_q;
        if (start_i) begin
            d_d.sh  = {{(NDIG*4){1'b0}}, value_i};
            d_d.cnt = CW'(DW);
        end else if (d_q.cnt != '0) begin
            d_d.sh  = {adj[SW-2:0], 1'b0};
            d_d.cnt = d_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign idle_o = (d_q.cnt == '0);
endmodule

// File: rtl/bcd_xfer_seq.sv
module bcd_xfer_seq
    import bxs_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 8,
    parameter int RN = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    input  logic [1:0]             cmd_op,
    input  logic [$clog2(RN)-1:0]  cmd_reg,
    input  logic [AW-1:0]          cmd_index,
    output logic                   busy,
    output logic                   done,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_waddr,
    output logic [DW-1:0]          mem_wdata,
    output logic                   mem_re,
    output logic [AW-1:0]          mem_raddr,
    input  logic [DW-1:0]          mem_rdata,
    output logic [$clog2(RN)-1:0]  rf_raddr,
    input  logic [DW-1:0]          rf_rdata,
    output logic                   rf_we,
    output logic [$clog2(RN)-1:0]  rf_waddr,
    output logic [DW-1:0]          rf_wdata
);
    localparam int RW   = $clog2(RN);
    localparam int NDIG = (DW * 301 + 999) / 1000;
    localparam int DIGW = (NDIG > 1) ? $clog2(NDIG) : 1;

    typedef struct packed {
        bxs_state_e     st;
        logic [RW-1:0]  last;
        logic [AW-1:0]  base;
        logic [RW-1:0]  cnt;
        logic           pend;
        logic [RW-1:0]  pend_idx;
    } seq_t;

    seq_t s_d, s_q;

    logic                 dab_start;
    logic                 dab_idle;
    logic [NDIG-1:0][3:0] dab_digits;
    logic [AW-1:0]        addr_cur;
    logic [DIGW-1:0]      dig_sel;
    logic [3:0]           cur_digit;
    logic                 bcd_phase;

    bxs_dabble #(.DW(DW), .NDIG(NDIG)) u_dabble (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (dab_start),
        .value_i  (rf_rdata),
        .idle_o   (dab_idle),
        .digits_o (dab_digits)
    );

    bxs_addr_wrap #(.AW(AW), .OW(RW)) u_addr (
        .base_i (s_q.base),
        .off_i  (s_q.cnt),
        .addr_o (addr_cur)
    );

    // most significant digit goes to the lowest address
    assign dig_sel   = DIGW'(NDIG - 1) - DIGW'(s_q.cnt);
    assign cur_digit = dab_digits[dig_sel];
    assign bcd_phase = (s_q.st == ST_BCD_WR);

    always_comb begin
        s_d       = s_q;
        s_d.pend  = 1'b0;
        dab_start = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        rf_raddr  = s_q.cnt;

        unique case (s_q.st)
            ST_IDLE: begin
                if (cmd_valid && (bxs_op_e'(cmd_op) != OP_NONE)) begin
                    s_d.last = cmd_reg;
                    s_d.base = cmd_index;
                    s_d.cnt  = '0;
                    unique case (bxs_op_e'(cmd_op))
                        OP_BCD:   s_d.st = ST_BCD_RD;
                        OP_STORE: s_d.st = ST_STORE;
                        default:  s_d.st = ST_LOAD;
                    endcase
                end
            end
            ST_BCD_RD: begin
                rf_raddr  = s_q.last;
                dab_start = 1'b1;
                s_d.st    = ST_BCD_CONV;
            end
            ST_BCD_CONV: begin
                if (dab_idle) begin
                    s_d.st  = ST_BCD_WR;
                    s_d.cnt = '0;
                end
            end
            ST_BCD_WR: begin
                mem_we    = 1'b1;
                mem_wdata = DW'(cur_digit);
                if (s_q.cnt == RW'(NDIG - 1)) s_d.st  = ST_FIN;
                else                          s_d.cnt = s_q.cnt + RW'(1);
            end
            ST_STORE: begin
                mem_we    = 1'b1;
                mem_wdata = rf_rdata;
                if (s_q.cnt == s_q.last) s_d.st  = ST_FIN;
                else                     s_d.cnt = s_q.cnt + RW'(1);
            end
            ST_LOAD: begin
                mem_re       = 1'b1;
                s_d.pend     = 1'b1;
                s_d.pend_idx = s_q.cnt;
                if (s_q.cnt == s_q.last) s_d.st  = ST_LOAD_TAIL;
                else                     s_d.cnt = s_q.cnt + RW'(1);
            end
            ST_LOAD_TAIL: begin
                s_d.st = ST_FIN;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign mem_waddr = addr_cur;
    assign mem_raddr = addr_cur;
    assign rf_we     = s_q.pend;
    assign rf_waddr  = s_q.pend_idx;
    assign rf_wdata  = mem_rdata;
    assign busy      = (s_q.st != ST_IDLE);
    assign done      = (s_q.st == ST_FIN);
endmodule

// File: rtl/bxs_chk.sv
module bxs_chk #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          mem_we,
    input logic          mem_re,
    input logic          rf_we,
    input logic [AW-1:0] mem_waddr,
    input logic [DW-1:0] mem_wdata,
    input logic          bcd_phase
);
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !rf_we));

    // R7
    done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_we && !mem_re && !rf_we));

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && !done));

    // R3
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && bcd_phase) |-> (mem_wdata <= DW'(9)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_waddr == $past(mem_waddr) + AW'(1)));

    // R5
    fill_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> $past(mem_re));
endmodule

bind bcd_xfer_seq bxs_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .rf_we     (rf_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .bcd_phase (bcd_phase)
);

// File: tb/tb_bcd_xfer_seq.sv
module tb_bcd_xfer_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [3:0]  cmd_reg = '0;
    logic [11:0] cmd_index = '0;
    logic        busy, done, mem_we, mem_re, rf_we;
    logic [11:0] mem_waddr, mem_raddr;
    logic [7:0]  mem_wdata, mem_rdata, rf_rdata, rf_wdata;
    logic [3:0]  rf_raddr, rf_waddr;

    logic [7:0] mem [4096];
    logic [7:0] exp_mem [4096];
    logic [7:0] rf [16];
    logic [7:0] exp_rf [16];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int last_acc = 0;
    logic prev_done = 1'b0;

    always #10 clk = ~clk;

    bcd_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_reg(cmd_reg), .cmd_index(cmd_index), .busy(busy), .done(done),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    assign rf_rdata = rf[rf_raddr];

    always @(posedge clk) begin
        if (mem_we) mem[mem_waddr] <= mem_wdata;
        mem_rdata <= mem_re ? mem[mem_raddr] : 8'h00;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // completion pulse timing monitor, sampled on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_we || mem_re || rf_we) last_acc = cyc;
            if (done) begin
                chk(cyc == last_acc + 1, "R7 done one cycle after last access", cyc - last_acc, 1);
                chk(!prev_done, "R7 done single cycle", int'(prev_done), 0);
            end
            if (mem_we && mem_re) chk(1'b0, "R8 write and read together", 1, 0);
        end
        prev_done = done;
    end

    task automatic issue(input logic [1:0] op, input logic [3:0] x, input logic [11:0] idx);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_reg = x; cmd_index = idx;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(done, {req, " completion seen"}, int'(done), 1);
        @(negedge clk);
        chk(!busy, {req, " idle after done"}, int'(busy), 0);
    endtask

    task automatic compare_mem(input string req);
        int bad = 0;
        for (int a = 0; a < 4096; a++) if (mem[a] !== exp_mem[a]) bad++;
        chk(bad == 0, {req, " memory image"}, bad, 0);
    endtask

    task automatic seed(input logic [7:0] salt);
        for (int a = 0; a < 4096; a++) begin
            mem[a] = 8'(a * 7) ^ salt;
            exp_mem[a] = mem[a];
        end
        for (int r = 0; r < 16; r++) begin
            rf[r] = 8'(r * 17 + 5) ^ salt;
            exp_rf[r] = rf[r];
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 busy/done in reset", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re && !rf_we, "R1 idle after reset",
            int'({busy, done, mem_we, mem_re, rf_we}), 0);
    endtask

    task automatic t_bcd(input logic [7:0] val, input logic [3:0] x, input logic [11:0] idx);
        rf[x] = val; exp_rf[x] = val;
        exp_mem[idx]        = val / 100;
        exp_mem[idx + 12'd1] = (val / 10) % 10;
        exp_mem[idx + 12'd2] = val % 10;
        issue(2'b01, x, idx);
        wait_done("R3");
        chk(mem[idx] == val / 100, "R3 hundreds", mem[idx], val / 100);
        chk(mem[idx + 12'd1] == (val / 10) % 10, "R3 tens", mem[idx + 12'd1], (val / 10) % 10);
        chk(mem[idx + 12'd2] == val % 10, "R3 ones", mem[idx + 12'd2], val % 10);
        compare_mem("R8 digit store");
    endtask

    task automatic t_store(input logic [3:0] x, input logic [11:0] idx, input string req);
        for (int k = 0; k <= int'(x); k++) exp_mem[idx + 12'(k)] = rf[k];
        issue(2'b10, x, idx);
        wait_done(req);
        for (int k = 0; k <= int'(x); k++)
            chk(mem[idx + 12'(k)] == rf[k], {req, " R4 spill byte"}, mem[idx + 12'(k)], rf[k]);
        compare_mem({req, " R8 spill"});
    endtask

    task automatic t_load(input logic [3:0] x, input logic [11:0] idx, input string req);
        for (int k = 0; k <= int'(x); k++) exp_rf[k] = mem[idx + 12'(k)];
        issue(2'b11, x, idx);
        wait_done(req);
        for (int k = 0; k < 16; k++)
            chk(rf[k] == exp_rf[k], {req, " R5 register after fill"}, rf[k], exp_rf[k]);
        compare_mem({req, " R8 fill"});
    endtask

    task automatic t_busy_ignore();
        for (int k = 0; k <= 3; k++) exp_mem[12'h300 + 12'(k)] = rf[k];
        issue(2'b10, 4'd3, 12'h300);
        cmd_valid = 1'b1; cmd_op = 2'b01; cmd_reg = 4'd9; cmd_index = 12'h500;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'b00;
        wait_done("R2 busy command");
        repeat (3) begin
            @(negedge clk);
            chk(!busy && !mem_we, "R2 command while busy ignored", int'({busy, mem_we}), 0);
        end
        compare_mem("R2 busy command");
    endtask

    task automatic t_noop();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_reg = 4'd15; cmd_index = 12'h123;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) begin
            chk(!busy && !mem_we && !mem_re && !rf_we, "R2 op 00 ignored",
                int'({busy, mem_we, mem_re, rf_we}), 0);
            @(negedge clk);
        end
        compare_mem("R2 op 00");
    endtask

    initial begin
        #3000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        seed(8'h00);
        t_reset();
        t_bcd(8'd0,   4'd7,  12'h100);
        t_bcd(8'd9,   4'd0,  12'h110);
        t_bcd(8'd10,  4'd15, 12'h120);
        t_bcd(8'd99,  4'd3,  12'h130);
        t_bcd(8'd100, 4'd4,  12'h140);
        t_bcd(8'd137, 4'd5,  12'h150);
        t_bcd(8'd255, 4'd6,  12'h160);
        t_bcd(8'd208, 4'd2,  12'hFFE);   // R6 digits wrap past top
        seed(8'h5A);
        t_store(4'd0,  12'h200, "R9 x=0");
        t_store(4'd15, 12'h210, "R9 x=15");
        t_store(4'd5,  12'hFFD, "R6 wrap");
        seed(8'hC3);
        t_load(4'd0,  12'h400, "R9 x=0");
        t_load(4'd15, 12'h410, "R9 x=15");
        t_load(4'd3,  12'hFFE, "R6 wrap");
        seed(8'h21);
        t_busy_ignore();
        t_noop();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule